// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block guards a small microcontroller core against runaway software. It counts ticks from one of two sources, chosen by a static build option. One source is a slow free-running oscillator input, which is synchronized into the core clock domain and edge-detected. The other is the instruction clock, one tick every four core clocks. The ticks pass through a fixed binary divider of 2^FIX_BITS stages (512 by default) and then through a programmable prescaler. The prescaler ratio is 1:2^code, where code is a 3-bit select field in a memory-mapped control register. Software must restart the count before it expires.

When the count expires while the core is running, the block issues a one-cycle full chip-reset request and sets a sticky timeout flag. When it expires while the core is halted, the block issues only a one-cycle warm-reset request, which the core uses to zero its program counter and stack pointer, and the flag is left alone. The count restarts from zero on external reset, on a software clear strobe, and on execution of a halt instruction. The upper five bits of the control register are free flags for software and have no effect on timing. A build option removes the watchdog function entirely.

Top module: `wdt_top`

## Requirements
- R1: With SRC=0 each rising edge of `osc_in`, seen through a two-flop synchronizer, is one tick. With SRC=1 one tick occurs every 4 core clocks and `osc_in` is ignored.
- R2: The count expires after exactly 2^FIX_BITS × 2^code ticks, where code is bits [2:0] of the control register at address REG_ADDR (default 7'h09). Codes 0..7 give prescale ratios 1:1 through 1:128.
- R3: Bits [7:3] of the control register are user flags. Writes to them read back unchanged and do not change the timing. The register resets to CTRL_RST (default 8'h07), and reads of any other address return 8'h00.
- R4: Expiry while `halted`=0 produces `chip_rst_req` high for exactly one cycle and sets `to_flag`.
- R5: Expiry while `halted`=1 produces `warm_rst_req` high for exactly one cycle, no `chip_rst_req`, and leaves `to_flag` unchanged.
- R6: `rst_n` low, a `clr_wdt` strobe, or a `halt_exec` strobe restarts the count from zero.
- R7: With SRC=1, no ticks are counted while `halted`=1, so no request is produced during halt.
- R8: With WDT_EN=0 no request is ever produced and `to_flag` stays 0, whatever the clears and source activity.
- R9: `to_flag` stays set until `rst_n` is low or `clr_to` is strobed.
- R10: After an expiry the count restarts from zero, so the next expiry follows one full period later.
- R11: `chip_rst_req` and `warm_rst_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | External reset, active low |
| osc_in | input | 1 | Slow watchdog oscillator, asynchronous |
| halted | input | 1 | Core is in halt state |
| halt_exec | input | 1 | Strobe: halt instruction executed, restarts the count |
| clr_wdt | input | 1 | Strobe: software watchdog clear |
| clr_to | input | 1 | Strobe: clear the timeout flag |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Register write enable |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational |
| chip_rst_req | output | 1 | One-cycle full chip-reset request |
| warm_rst_req | output | 1 | One-cycle warm-reset request |
| to_flag | output | 1 | Sticky timeout status |

## Verification
The bench steps through every select code and stops one tick short of expiry, then adds the last tick. A tap mux that is off by one stage, or a prescaler not cleared on expiry, shows up as an early, late or missing request. It clears the count one tick before expiry with each clear source. A clear that missed either the fixed divider or the prescaler would let the request fire early. It times out while halted and expects the warm request with the flag untouched. A design that ignored the mode would raise the chip request or set the flag. It also holds an instruction-clock instance in halt for longer than a period, checks its exact period, and checks that a disabled instance stays silent.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int CTRL_W = 8;
   localparam int SEL_W  = 3;
   localparam int USER_W = CTRL_W - SEL_W;

   typedef enum logic {
      SRC_OSC  = 1'b0,
      SRC_ICLK = 1'b1
   } wdt_src_e;

   typedef struct packed {
      logic [USER_W-1:0] user;
      logic [SEL_W-1:0]  sel;
   } wdt_ctrl_t;
endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src
   import wdt_pkg::*;
#(
   parameter wdt_src_e SRC         = SRC_OSC,
   parameter int       SYNC_STAGES = 2,
   parameter int       ICLK_DIV    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_in,
   input  logic halted,
   output logic tick
);
   localparam int DIV_W = (ICLK_DIV > 1) ? $clog2(ICLK_DIV) : 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wdt_tick_src: SYNC_STAGES must be at least 2");
      end
      if (ICLK_DIV < 2) begin : g_bad_div
         $error("wdt_tick_src: ICLK_DIV must be at least 2");
      end

      if (SRC == SRC_OSC) begin : g_osc
         logic [SYNC_STAGES:0] shreg;
         logic                 unused_halted;
         assign unused_halted = halted;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shreg <= '0;
            else        shreg <= {shreg[SYNC_STAGES-1:0], osc_in};
         end
         assign tick = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
      end else begin : g_iclk
         logic [DIV_W-1:0] phase;
         logic             unused_osc;
         assign unused_osc = osc_in;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase <= '0;
            end else if (!halted) begin
               if (phase == DIV_W'(ICLK_DIV - 1)) phase <= '0;
               else                               phase <= phase + 1'b1;
            end
         end
         assign tick = !halted && (phase == DIV_W'(ICLK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/wdt_divchain.sv
module wdt_divchain
   import wdt_pkg::*;
#(
   parameter int FIX_BITS = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);
   localparam int NTAP     = 1 << SEL_W;
   localparam int PRE_BITS = NTAP - 1;

   logic [FIX_BITS-1:0] fix_cnt;
   logic [PRE_BITS-1:0] pre_cnt;
   logic                carry;
   logic [NTAP-1:0]     tap;

   generate
      if (FIX_BITS < 1) begin : g_bad_fix
         $error("wdt_divchain: FIX_BITS must be at least 1");
      end
   endgenerate

   assign carry = tick & (&fix_cnt);

   generate
      for (genvar k = 0; k < NTAP; k++) begin : g_tap
         if (k == 0) begin : g_first
            assign tap[k] = 1'b1;
         end else begin : g_rest
            assign tap[k] = &pre_cnt[k-1:0];
         end
      end
   endgenerate

   assign expire = carry & tap[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fix_cnt <= '0;
      end else if (clr) begin
         fix_cnt <= '0;
      end else if (tick) begin
         fix_cnt <= fix_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
      end else if (clr || expire) begin
         pre_cnt <= '0;
      end else if (carry) begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
   import wdt_pkg::*;
#(
   parameter int          ADDR_W   = 7,
   parameter logic [6:0]  REG_ADDR = 7'h09,
   parameter logic [7:0]  CTRL_RST = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CTRL_W-1:0] bus_wdata,
   output logic [CTRL_W-1:0] bus_rdata,
   output wdt_ctrl_t         ctrl
);
   logic hit;

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("wdt_ctrl_reg: ADDR_W must be at least 7");
      end
   endgenerate

   assign hit = (bus_addr == ADDR_W'(REG_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ctrl <= wdt_ctrl_t'(CTRL_RST);
      else if (bus_wr && hit) ctrl <= wdt_ctrl_t'(bus_wdata);
   end

   assign bus_rdata = hit ? CTRL_W'(ctrl) : '0;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
   import wdt_pkg::*;
#(
   parameter bit          WDT_EN   = 1'b1,
   parameter wdt_src_e    SRC      = SRC_OSC,
   parameter int          FIX_BITS = 9,
   parameter int          ADDR_W   = 7,
   parameter logic [6:0]  REG_ADDR = 7'h09,
   parameter logic [7:0]  CTRL_RST = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_in,
   input  logic              halted,
   input  logic              halt_exec,
   input  logic              clr_wdt,
   input  logic              clr_to,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              chip_rst_req,
   output logic              warm_rst_req,
   output logic              to_flag
);
   wdt_ctrl_t ctrl;
   logic      expire;
   logic      cnt_clr;

   assign cnt_clr = clr_wdt | halt_exec;

   wdt_ctrl_reg #(
      .ADDR_W  (ADDR_W),
      .REG_ADDR(REG_ADDR),
      .CTRL_RST(CTRL_RST)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .ctrl     (ctrl)
   );

   generate
      if (WDT_EN) begin : g_on
         logic tick;

         wdt_tick_src #(.SRC(SRC)) u_src (
            .clk   (clk),
            .rst_n (rst_n),
            .osc_in(osc_in),
            .halted(halted),
            .tick  (tick)
         );

         wdt_divchain #(.FIX_BITS(FIX_BITS)) u_chain (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .clr   (cnt_clr),
            .sel   (ctrl.sel),
            .expire(expire)
         );
      end else begin : g_off
         logic unused_in;
         assign unused_in = ^{osc_in, cnt_clr, ctrl.sel};
         assign expire    = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chip_rst_req <= 1'b0;
         warm_rst_req <= 1'b0;
      end else begin
         chip_rst_req <= expire & ~halted;
         warm_rst_req <= expire &  halted;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  to_flag <= 1'b0;
      else if (expire && !halted)  to_flag <= 1'b1;
      else if (clr_to)             to_flag <= 1'b0;
   end
endmodule

// File: rtl/wdt_top_chk.sv
module wdt_top_chk #(
   parameter bit WDT_EN = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic halted,
   input logic clr_to,
   input logic chip_rst_req,
   input logic warm_rst_req,
   input logic to_flag
);
   assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(chip_rst_req && warm_rst_req));

   assert_chip_when_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_req |-> !$past(halted));

   assert_chip_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_req |-> to_flag);

   assert_chip_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_req |=> !chip_rst_req);

   assert_warm_when_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_req |-> $past(halted));

   assert_warm_keeps_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_rst_req && !$past(clr_to)) |-> $stable(to_flag));

   assert_warm_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_req |=> !warm_rst_req);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag && !clr_to) |=> to_flag);

   generate
      if (!WDT_EN) begin : g_off_chk
         assert_disabled_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !chip_rst_req && !warm_rst_req && !to_flag);
      end
   endgenerate
endmodule

bind wdt_top wdt_top_chk #(.WDT_EN(WDT_EN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .halted      (halted),
   .clr_to      (clr_to),
   .chip_rst_req(chip_rst_req),
   .warm_rst_req(warm_rst_req),
   .to_flag     (to_flag)
);

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
module sim_wdt_top;
   import wdt_pkg::*;

   localparam int FIXB = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_in = 1'b0;
   logic       halted = 1'b0;
   logic       halt_exec = 1'b0;
   logic       clr_wdt = 1'b0;
   logic       clr_to = 1'b0;
   logic [6:0] bus_addr = 7'h09;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] rd0, rd1, rd2;
   logic       chip0, warm0, flag0;
   logic       chip1, warm1, flag1;
   logic       chip2, warm2, flag2;

   int errors = 0;
   int checks = 0;
   int nchip0 = 0, nwarm0 = 0, nchip1 = 0, nwarm1 = 0, nchip2 = 0, nwarm2 = 0;

   always #4 clk = ~clk;

   wdt_top #(.SRC(SRC_OSC), .FIX_BITS(FIXB)) u0 (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .halted(halted),
      .halt_exec(halt_exec), .clr_wdt(clr_wdt), .clr_to(clr_to),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(rd0), .chip_rst_req(chip0), .warm_rst_req(warm0), .to_flag(flag0)
   );

   wdt_top #(.SRC(SRC_ICLK), .CTRL_RST(8'h00)) u1 (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .halted(halted),
      .halt_exec(halt_exec), .clr_wdt(clr_wdt), .clr_to(clr_to),
      .bus_addr(bus_addr), .bus_wr(1'b0), .bus_wdata(bus_wdata),
      .bus_rdata(rd1), .chip_rst_req(chip1), .warm_rst_req(warm1), .to_flag(flag1)
   );

   wdt_top #(.WDT_EN(1'b0), .FIX_BITS(FIXB), .CTRL_RST(8'h00)) u2 (
      .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .halted(halted),
      .halt_exec(halt_exec), .clr_wdt(clr_wdt), .clr_to(clr_to),
      .bus_addr(bus_addr), .bus_wr(1'b0), .bus_wdata(bus_wdata),
      .bus_rdata(rd2), .chip_rst_req(chip2), .warm_rst_req(warm2), .to_flag(flag2)
   );

   always @(negedge clk) begin
      if (chip0) nchip0++;
      if (warm0) nwarm0++;
      if (chip1) nchip1++;
      if (warm1) nwarm1++;
      if (chip2) nchip2++;
      if (warm2) nwarm2++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic osc_edges(input int n);
      repeat (n) begin
         @(negedge clk) osc_in = 1'b1;
         @(negedge clk);
         @(negedge clk) osc_in = 1'b0;
         @(negedge clk);
      end
      cycles(4);
   endtask

   task automatic wbus(input logic [7:0] d);
      @(negedge clk) begin bus_addr = 7'h09; bus_wdata = d; bus_wr = 1'b1; end
      @(negedge clk) bus_wr = 1'b0;
   endtask

   task automatic sw_clr;
      @(negedge clk) clr_wdt = 1'b1;
      @(negedge clk) clr_wdt = 1'b0;
   endtask

   task automatic flag_clr;
      @(negedge clk) clr_to = 1'b1;
      @(negedge clk) clr_to = 1'b0;
   endtask

   localparam logic [7:0] VEC [0:7] = '{8'hA8, 8'h51, 8'hFA, 8'h03,
                                        8'h8C, 8'h35, 8'hDE, 8'h27};

   initial begin
      repeat (120000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R2: run did not complete actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int base, basew, per;
      cycles(5);
      rst_n = 1'b1;
      cycles(2);

      // R3 reset state and unmapped address
      #1;
      chk(rd0 == 8'h07, "R3", "reset value", rd0, 8'h07);
      chk(flag0 == 1'b0, "R9", "flag after reset", flag0, 0);
      bus_addr = 7'h08;
      #1;
      chk(rd0 == 8'h00, "R3", "unmapped read", rd0, 0);
      bus_addr = 7'h09;

      // R1 instruction-clock source: period 512*4 cycles at code 0
      sw_clr;
      base = nchip1;
      cycles(2036);
      chk(nchip1 == base, "R1", "iclk early request", nchip1 - base, 0);
      cycles(24);
      chk(nchip1 == base + 1, "R1", "iclk period", nchip1 - base, 1);

      // R7 instruction-clock source frozen while halted
      @(negedge clk) begin halted = 1'b1; halt_exec = 1'b1; end
      @(negedge clk) halt_exec = 1'b0;
      base = nchip1; basew = nwarm1;
      cycles(3000);
      chk(nchip1 == base && nwarm1 == basew, "R7", "iclk requests in halt",
          (nchip1 - base) + (nwarm1 - basew), 0);
      @(negedge clk) halted = 1'b0;
      flag_clr;

      // R2 every select code, table walk
      for (int i = 0; i < 8; i++) begin
         per = (1 << FIXB) << VEC[i][2:0];
         wbus(VEC[i]);
         sw_clr;
         base = nchip0; basew = nwarm0;
         osc_edges(per - 1);
         chk(nchip0 == base, "R2", $sformatf("early request code %0d", VEC[i][2:0]),
             nchip0 - base, 0);
         osc_edges(1);
         chk(nchip0 == base + 1, "R2", $sformatf("request at period code %0d", VEC[i][2:0]),
             nchip0 - base, 1);
         chk(flag0 == 1'b1 && nwarm0 == basew, "R4", "flag set, no warm",
             flag0, 1);
         #1;
         chk(rd0 == VEC[i], "R3", "user bits read back", rd0, VEC[i]);
         flag_clr;
      end

      // R10 restart after expiry
      wbus(8'hF8);
      sw_clr;
      base = nchip0;
      osc_edges(32);
      chk(nchip0 == base + 1, "R10", "first expiry", nchip0 - base, 1);
      osc_edges(31);
      chk(nchip0 == base + 1, "R10", "no early second", nchip0 - base, 1);
      osc_edges(1);
      chk(nchip0 == base + 2, "R10", "second expiry", nchip0 - base, 2);

      // R9 flag holds, cleared by strobe
      cycles(100);
      chk(flag0 == 1'b1, "R9", "flag holds", flag0, 1);
      flag_clr;
      chk(flag0 == 1'b0, "R9", "flag cleared", flag0, 0);

      // R6 software clear one tick before expiry
      sw_clr;
      base = nchip0;
      osc_edges(31);
      sw_clr;
      osc_edges(31);
      chk(nchip0 == base, "R6", "sw clear restarts", nchip0 - base, 0);
      osc_edges(1);
      chk(nchip0 == base + 1, "R6", "expiry after sw clear", nchip0 - base, 1);

      // R6 halt instruction clear, with prescaler stage in use (code 1)
      wbus(8'h01);
      sw_clr;
      base = nchip0;
      osc_edges(63);
      @(negedge clk) halt_exec = 1'b1;
      @(negedge clk) halt_exec = 1'b0;
      osc_edges(63);
      chk(nchip0 == base, "R6", "halt clear restarts", nchip0 - base, 0);
      osc_edges(1);
      chk(nchip0 == base + 1, "R6", "expiry after halt clear", nchip0 - base, 1);
      flag_clr;

      // R5 expiry while halted gives warm request only
      wbus(8'h00);
      @(negedge clk) begin halted = 1'b1; halt_exec = 1'b1; end
      @(negedge clk) halt_exec = 1'b0;
      base = nchip0; basew = nwarm0;
      osc_edges(32);
      chk(nwarm0 == basew + 1, "R5", "warm request", nwarm0 - basew, 1);
      chk(nchip0 == base, "R5", "no chip request in halt", nchip0 - base, 0);
      chk(flag0 == 1'b0, "R5", "flag untouched in halt", flag0, 0);
      @(negedge clk) halted = 1'b0;

      // R9 external reset clears flag
      sw_clr;
      osc_edges(32);
      chk(flag0 == 1'b1, "R4", "flag set before reset", flag0, 1);
      @(negedge clk) rst_n = 1'b0;
      cycles(2);
      chk(flag0 == 1'b0, "R9", "flag cleared by reset", flag0, 0);
      @(negedge clk) rst_n = 1'b1;
      cycles(2);

      // R8 disabled instance stayed silent all run
      chk(nchip2 == 0 && nwarm2 == 0, "R8", "disabled requests", nchip2 + nwarm2, 0);
      chk(flag2 == 1'b0, "R8", "disabled flag", flag2, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule